// File: doc/BRIEF.md
# Camera Packet Header and Payload Checker

This block sits behind the lane-merging stage of a camera serial receiver. It takes a stream of 32-bit words, where a start flag marks the first word of every packet, and parses that stream into packets. A short packet is one header word. A long packet is one header word followed by the payload bytes and a two-byte checksum, packed four bytes to a word with the lowest byte first.

Each header is protected by a 6-bit code. The block repairs any single flipped bit in the header and discards the whole packet when it finds an error it cannot repair. For long packets it recomputes the payload checksum and compares it with the one received. A per-channel enable mask drops the packets of unwanted virtual channels. The surviving short packets, payload words and end-of-packet verdicts leave on three separate output groups. Each output carries the channel and data type of its own packet, so channels and types may interleave in any order.

Error events are held in sticky status bits. Each bit stays set until it is cleared bit by bit. Three masked error classes drive a single interrupt line.

Top module: `csi_pkt_check`

## Requirements
- R1: Header word layout: bits [5:0] data type, [7:6] virtual channel, [23:8] word count, [29:24] check code. A data type of 0x0F or below marks a short packet. An accepted short packet produces one `sp_valid` pulse, one cycle after its header word, with `sp_data` equal to the 16-bit field. `sp_valid` and `pay_valid` are never high together.
- R2: A long packet with word count N is followed by ceil((N+2)/4) words. Stream bytes 0..N-1 are payload, byte N is the low checksum byte, byte N+1 is the high checksum byte, and any bytes after that are padding. Each word that holds payload is output one cycle after it arrives. `pay_keep` marks the payload bytes from byte 0 upward. Unmarked bytes read zero. `pay_first` marks the first such word and `pay_last` marks the final one. Any N, including 0, is accepted.
- R3: The check code is the XOR of one 6-bit column for each set bit among header bits [23:0]. The column for bit i is the i-th 6-bit value, counting upward, among the values of weight 3, followed by the values of weight 5 (7, 11, 13, 14, …, 56, 31, 47, 55, 59). A single flipped bit, in the data or in the code, is repaired: the outputs are those of the clean packet, and status bit 1 is set.
- R4: A header with an error that cannot be repaired (an even-weight syndrome, or an odd one that matches no column) discards the whole packet. It sets status bit 2, and the words that follow without a start flag are ignored until the next start flag.
- R5: The long-packet checksum is a CRC-16 with polynomial x^16+x^12+x^5+1, seed 0xFFFF, and no final inversion. It is computed over the payload bytes, least significant bit first, and compared with the received bytes. One cycle after the final word, `end_valid` pulses with `end_crc_err` set on a mismatch, and a mismatch also sets status bit 3.
- R6: A packet whose channel bit in `vc_enable` is 0 produces no output and no checksum verdict.
- R7: Channel and data type may change on every packet, and each output carries the values from its own packet's header.
- R8: A start flag that arrives while payload is still expected ends the old packet: an accepted old packet gets `end_valid` with `end_trunc`. Status bit 4 is set, and the new word is parsed as a header.
- R9: A word without a start flag that arrives while no packet is open, and not after a discarded header, sets status bit 4.
- R10: Status bits are sticky. A 1 on a `status_clr` bit clears that bit, but a new event in the same cycle wins. `irq` is high when an enabled class has a set bit: class 0 is bit 0, class 1 is bits 2–3, class 2 is bit 4. Bit 1 raises no interrupt.
- R11: A pulse on `in_phy_err` sets status bit 0.
- R12: After reset all output pulses, `status` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_sot | input | 1 | Input word is the first word of a packet |
| in_data | input | 32 | Input word, lowest byte first |
| in_phy_err | input | 1 | Error pulse from the physical layer |
| vc_enable | input | 4 | Accept mask, one bit per virtual channel |
| irq_enable | input | 3 | Interrupt enable per error class |
| status_clr | input | 5 | Per-bit clear of the sticky status |
| sp_valid | output | 1 | Short packet output pulse |
| sp_vc | output | 2 | Short packet channel |
| sp_dt | output | 6 | Short packet data type |
| sp_data | output | 16 | Short packet data field |
| pay_valid | output | 1 | Payload word valid |
| pay_data | output | 32 | Payload word |
| pay_keep | output | 4 | Payload byte marks |
| pay_first | output | 1 | First payload word of the packet |
| pay_last | output | 1 | Final payload word of the packet |
| pay_vc | output | 2 | Channel of the payload word |
| pay_dt | output | 6 | Data type of the payload word |
| end_valid | output | 1 | End-of-packet verdict pulse |
| end_crc_err | output | 1 | Checksum mismatch |
| end_trunc | output | 1 | Packet cut short by a new start flag |
| status | output | 5 | Sticky error bits |
| irq | output | 1 | Interrupt |

## Verification
Some properties can be checked on every cycle. Short-packet and payload outputs never overlap. Payload marks are always contiguous, and every non-final payload word is full. Status bits are sticky against everything except their own clear. A physical-layer pulse always sets its bit. The checksum and truncation verdicts always show up in the status register. An idle status never raises the interrupt. Other behaviour only shows in the bench's scenarios. These include the exact repaired header contents, the discard of a packet with a double error and the resume at the next start flag, the checksum value itself, the channel filter, word counts of zero and of a few dozen, and the interrupt masking per class.

// File: rtl/csi_pkt_pkg.sv
package csi_pkt_pkg;

   localparam int WORD_W = 32;
   localparam int BYTES  = WORD_W / 8;
   localparam int VC_W   = 2;
   localparam int VC_N   = 1 << VC_W;
   localparam int DT_W   = 6;
   localparam int WC_W   = 16;
   localparam int HDR_W  = DT_W + VC_W + WC_W;
   localparam int ECC_W  = 6;
   localparam int ST_W   = 5;
   localparam int IRQ_W  = 3;

   localparam int ST_PHY   = 0;
   localparam int ST_FIX   = 1;
   localparam int ST_HDR   = 2;
   localparam int ST_CRC   = 3;
   localparam int ST_PROTO = 4;

   typedef struct packed {
      logic [WC_W-1:0] wc;
      logic [VC_W-1:0] vc;
      logic [DT_W-1:0] dt;
   } csi_hdr_t;

   // column of header bit idx: weight-3 codes ascending, then weight-5 codes
   function automatic logic [ECC_W-1:0] ecc_col(input int idx);
      int n;
      logic [ECC_W-1:0] res;
      n   = 0;
      res = '0;
      for (int w = 3; w <= 5; w += 2) begin
         for (int v = 0; v < (1 << ECC_W); v++) begin
            if ($countones(v[ECC_W-1:0]) == w) begin
               if (n == idx) res = v[ECC_W-1:0];
               n++;
            end
         end
      end
      return res;
   endfunction

   function automatic logic [ECC_W-1:0] ecc_calc(input logic [HDR_W-1:0] d);
      logic [ECC_W-1:0] e;
      e = '0;
      for (int i = 0; i < HDR_W; i++) begin
         if (d[i]) e = e ^ ecc_col(i);
      end
      return e;
   endfunction

   function automatic logic [15:0] bit_rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b,
                                            input logic [15:0] poly_rev);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ poly_rev;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/csi_hdr_ecc.sv
module csi_hdr_ecc
   import csi_pkt_pkg::*;
#(
   parameter bit ECC_CORRECT = 1'b1
)(
   input  logic [HDR_W+ECC_W-1:0] word,
   output csi_hdr_t               hdr,
   output logic                   fixed,
   output logic                   bad
);

   logic [HDR_W-1:0] raw;
   logic [ECC_W-1:0] syn;
   logic [HDR_W-1:0] flip;
   logic             hit;

   assign raw = word[HDR_W-1:0];
   assign syn = ecc_calc(raw) ^ word[HDR_W+ECC_W-1:HDR_W];

   always_comb begin
      flip = '0;
      hit  = 1'b0;
      for (int i = 0; i < HDR_W; i++) begin
         if (syn == ecc_col(i)) begin
            flip[i] = 1'b1;
            hit     = 1'b1;
         end
      end
   end

   generate
      if (ECC_CORRECT) begin : g_sec
         logic repairable;
         assign repairable = (^syn) && (hit || ($countones(syn) == 1));
         assign hdr   = csi_hdr_t'(raw ^ flip);
         assign fixed = (syn != '0) && repairable;
         assign bad   = (syn != '0) && !repairable;
      end else begin : g_det
         logic unused_hit;
         assign unused_hit = hit ^ (^flip);
         assign hdr   = csi_hdr_t'(raw);
         assign fixed = 1'b0;
         assign bad   = (syn != '0);
      end
   endgenerate

endmodule

// File: rtl/csi_crc_word.sv
module csi_crc_word
   import csi_pkt_pkg::*;
#(
   parameter logic [15:0] POLY = 16'h1021,
   parameter int          NB   = BYTES
)(
   input  logic [15:0]     crc_in,
   input  logic [8*NB-1:0] data,
   input  logic [NB-1:0]   en,
   output logic [15:0]     crc_out
);

   localparam logic [15:0] POLY_REV = bit_rev16(POLY);

   always_comb begin
      crc_out = crc_in;
      for (int k = 0; k < NB; k++) begin
         if (en[k]) crc_out = crc_byte(crc_out, data[8*k +: 8], POLY_REV);
      end
   end

endmodule

// File: rtl/csi_pkt_check.sv
module csi_pkt_check
   import csi_pkt_pkg::*;
#(
   parameter int          SHORT_DT_LAST = 15,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_SEED      = 16'hFFFF,
   parameter bit          ECC_CORRECT   = 1'b1,
   parameter bit          ZERO_PAD      = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sot,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_phy_err,
   input  logic [VC_N-1:0]   vc_enable,
   input  logic [IRQ_W-1:0]  irq_enable,
   input  logic [ST_W-1:0]   status_clr,
   output logic              sp_valid,
   output logic [VC_W-1:0]   sp_vc,
   output logic [DT_W-1:0]   sp_dt,
   output logic [WC_W-1:0]   sp_data,
   output logic              pay_valid,
   output logic [WORD_W-1:0] pay_data,
   output logic [BYTES-1:0]  pay_keep,
   output logic              pay_first,
   output logic              pay_last,
   output logic [VC_W-1:0]   pay_vc,
   output logic [DT_W-1:0]   pay_dt,
   output logic              end_valid,
   output logic              end_crc_err,
   output logic              end_trunc,
   output logic [ST_W-1:0]   status,
   output logic              irq
);

   localparam int CNT_W = WC_W + 2;

   generate
      if (SHORT_DT_LAST < 0 || SHORT_DT_LAST >= (1 << DT_W)) begin : g_bad_dt
         $fatal(1, "SHORT_DT_LAST outside the data type range");
      end
      if (!CRC_POLY[0]) begin : g_bad_poly
         $fatal(1, "CRC_POLY needs the x^0 term");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_BODY, S_SKIP} state_t;

   state_t            st;
   logic [CNT_W-1:0]  pos;
   logic [WC_W-1:0]   wc_r;
   logic              acc_r;
   logic [VC_W-1:0]   vc_r;
   logic [DT_W-1:0]   dt_r;
   logic [15:0]       crc_r;
   logic [15:0]       rxcrc_r;

   csi_hdr_t          hdr;
   logic              hdr_fixed;
   logic              hdr_bad;
   logic              hdr_short;

   logic              is_hdr;
   logic              body_word;
   logic              trunc;
   logic              stray;

   logic [CNT_W-1:0]  wc_ext;
   logic [CNT_W-1:0]  bpos [BYTES];
   logic [BYTES-1:0]  keep_c;
   logic [15:0]       rx_next;
   logic [15:0]       crc_next;
   logic              last_c;
   logic              pay_last_c;
   logic              crc_bad_c;
   logic [WORD_W-1:0] pay_data_c;

   csi_hdr_ecc #(.ECC_CORRECT(ECC_CORRECT)) u_ecc (
      .word  (in_data[HDR_W+ECC_W-1:0]),
      .hdr   (hdr),
      .fixed (hdr_fixed),
      .bad   (hdr_bad)
   );

   csi_crc_word #(.POLY(CRC_POLY), .NB(BYTES)) u_crc (
      .crc_in  (crc_r),
      .data    (in_data),
      .en      (keep_c),
      .crc_out (crc_next)
   );

   assign hdr_short = (int'(hdr.dt) <= SHORT_DT_LAST);
   assign is_hdr    = in_valid && in_sot;
   assign body_word = in_valid && !in_sot && (st == S_BODY);
   assign trunc     = is_hdr && (st == S_BODY);
   assign stray     = in_valid && !in_sot && (st == S_IDLE);
   assign wc_ext    = CNT_W'(wc_r);

   always_comb begin
      rx_next = rxcrc_r;
      for (int k = 0; k < BYTES; k++) begin
         bpos[k]   = pos + CNT_W'(k);
         keep_c[k] = body_word && (bpos[k] < wc_ext);
         if (bpos[k] == wc_ext)               rx_next[7:0]  = in_data[8*k +: 8];
         if (bpos[k] == wc_ext + CNT_W'(1))   rx_next[15:8] = in_data[8*k +: 8];
      end
   end

   assign last_c     = (pos + CNT_W'(BYTES)) >= (wc_ext + CNT_W'(2));
   assign pay_last_c = (pos + CNT_W'(BYTES)) >= wc_ext;
   assign crc_bad_c  = (crc_next != rx_next);

   generate
      if (ZERO_PAD) begin : g_pad
         always_comb begin
            for (int k = 0; k < BYTES; k++) begin
               pay_data_c[8*k +: 8] = keep_c[k] ? in_data[8*k +: 8] : 8'h00;
            end
         end
      end else begin : g_raw
         assign pay_data_c = in_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         pos         <= '0;
         wc_r        <= '0;
         acc_r       <= 1'b0;
         vc_r        <= '0;
         dt_r        <= '0;
         crc_r       <= CRC_SEED;
         rxcrc_r     <= '0;
         sp_valid    <= 1'b0;
         sp_vc       <= '0;
         sp_dt       <= '0;
         sp_data     <= '0;
         pay_valid   <= 1'b0;
         pay_data    <= '0;
         pay_keep    <= '0;
         pay_first   <= 1'b0;
         pay_last    <= 1'b0;
         pay_vc      <= '0;
         pay_dt      <= '0;
         end_valid   <= 1'b0;
         end_crc_err <= 1'b0;
         end_trunc   <= 1'b0;
      end else begin
         sp_valid    <= 1'b0;
         pay_valid   <= 1'b0;
         end_valid   <= 1'b0;
         end_crc_err <= 1'b0;
         end_trunc   <= 1'b0;
         if (is_hdr) begin
            if (trunc && acc_r) begin
               end_valid <= 1'b1;
               end_trunc <= 1'b1;
            end
            if (hdr_bad) begin
               st <= S_SKIP;
            end else if (hdr_short) begin
               st <= S_IDLE;
               if (vc_enable[hdr.vc]) begin
                  sp_valid <= 1'b1;
                  sp_vc    <= hdr.vc;
                  sp_dt    <= hdr.dt;
                  sp_data  <= hdr.wc;
               end
            end else begin
               st      <= S_BODY;
               pos     <= '0;
               wc_r    <= hdr.wc;
               acc_r   <= vc_enable[hdr.vc];
               vc_r    <= hdr.vc;
               dt_r    <= hdr.dt;
               crc_r   <= CRC_SEED;
               rxcrc_r <= '0;
            end
         end else if (body_word) begin
            pos     <= pos + CNT_W'(BYTES);
            crc_r   <= crc_next;
            rxcrc_r <= rx_next;
            if (acc_r && keep_c[0]) begin
               pay_valid <= 1'b1;
               pay_data  <= pay_data_c;
               pay_keep  <= keep_c;
               pay_first <= (pos == '0);
               pay_last  <= pay_last_c;
               pay_vc    <= vc_r;
               pay_dt    <= dt_r;
            end
            if (last_c) begin
               st <= S_IDLE;
               if (acc_r) begin
                  end_valid   <= 1'b1;
                  end_crc_err <= crc_bad_c;
               end
            end
         end
      end
   end

   logic [ST_W-1:0] st_set;

   always_comb begin
      st_set           = '0;
      st_set[ST_PHY]   = in_phy_err;
      st_set[ST_FIX]   = is_hdr && hdr_fixed;
      st_set[ST_HDR]   = is_hdr && hdr_bad;
      st_set[ST_CRC]   = body_word && last_c && acc_r && crc_bad_c;
      st_set[ST_PROTO] = trunc || stray;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~status_clr) | st_set;
   end

   assign irq = (irq_enable[0] && status[ST_PHY])
             || (irq_enable[1] && (status[ST_HDR] || status[ST_CRC]))
             || (irq_enable[2] && status[ST_PROTO]);

endmodule

// File: rtl/csi_pkt_check_sva.sv
module csi_pkt_check_sva
   import csi_pkt_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             in_phy_err,
   input logic [ST_W-1:0]  status_clr,
   input logic             sp_valid,
   input logic             pay_valid,
   input logic [BYTES-1:0] pay_keep,
   input logic             pay_last,
   input logic             end_valid,
   input logic             end_crc_err,
   input logic             end_trunc,
   input logic [ST_W-1:0]  status,
   input logic             irq
);

   // R1
   sp_pay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sp_valid && pay_valid));

   // R2
   keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> (pay_keep == 4'b0001 || pay_keep == 4'b0011 ||
                     pay_keep == 4'b0111 || pay_keep == 4'b1111));

   // R2
   full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid && !pay_last) |-> (pay_keep == 4'b1111));

   // R5
   crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_crc_err |-> (end_valid && status[ST_CRC]));

   // R8
   trunc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_trunc |-> (end_valid && status[ST_PROTO]));

   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(status) & ~$past(status_clr)) & ~status) == '0));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);

   // R11
   phy_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_phy_err |=> status[ST_PHY]);

endmodule

bind csi_pkt_check csi_pkt_check_sva u_sva (.*);

// File: tb/csi_pkt_check_test.sv
`timescale 1ns/1ps
module csi_pkt_check_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sot = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_phy_err = 1'b0;
   logic [3:0]  vc_enable = 4'hF;
   logic [2:0]  irq_enable = 3'b111;
   logic [4:0]  status_clr = '0;
   logic        sp_valid;
   logic [1:0]  sp_vc;
   logic [5:0]  sp_dt;
   logic [15:0] sp_data;
   logic        pay_valid;
   logic [31:0] pay_data;
   logic [3:0]  pay_keep;
   logic        pay_first;
   logic        pay_last;
   logic [1:0]  pay_vc;
   logic [5:0]  pay_dt;
   logic        end_valid;
   logic        end_crc_err;
   logic        end_trunc;
   logic [4:0]  status;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   csi_pkt_check uut (
      .clk, .rst_n, .in_valid, .in_sot, .in_data, .in_phy_err, .vc_enable,
      .irq_enable, .status_clr, .sp_valid, .sp_vc, .sp_dt, .sp_data,
      .pay_valid, .pay_data, .pay_keep, .pay_first, .pay_last, .pay_vc, .pay_dt,
      .end_valid, .end_crc_err, .end_trunc, .status, .irq
   );

   typedef struct { logic [1:0] vc; logic [5:0] dt; logic [15:0] data; string tag; } sp_item_t;
   typedef struct { logic [31:0] data; logic [3:0] keep; logic first; logic last;
                    logic [1:0] vc; logic [5:0] dt; string tag; } pay_item_t;
   typedef struct { logic crc_err; logic trunc; string tag; } end_item_t;

   sp_item_t  sp_q[$];
   pay_item_t pay_q[$];
   end_item_t end_q[$];

   localparam logic [5:0] ECOL [0:23] = '{
      6'd7, 6'd11, 6'd13, 6'd14, 6'd19, 6'd21, 6'd22, 6'd25, 6'd26, 6'd28,
      6'd35, 6'd37, 6'd38, 6'd41, 6'd42, 6'd44, 6'd49, 6'd50, 6'd52, 6'd56,
      6'd31, 6'd47, 6'd55, 6'd59};

   function automatic logic [31:0] make_hdr(input logic [1:0] vc, input logic [5:0] dt,
                                            input logic [15:0] wc);
      logic [23:0] d;
      logic [5:0]  e;
      d = {wc, vc, dt};
      e = '0;
      for (int i = 0; i < 24; i++) if (d[i]) e ^= ECOL[i];
      return {2'b00, e, d};
   endfunction

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] != b[i]) r = {1'b0, r[15:1]} ^ 16'h8408;
         else              r = {1'b0, r[15:1]};
      end
      return r;
   endfunction

   task automatic check_eq(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic send_word(input logic sot, input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_sot   = sot;
      in_data  = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sot   = 1'b0;
         in_data  = '0;
      end
   endtask

   task automatic send_short(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] d,
                             input logic [31:0] hflip, input bit expect_out, input string tag);
      if (expect_out) sp_q.push_back('{vc, dt, d, tag});
      send_word(1'b1, make_hdr(vc, dt, d) ^ hflip);
   endtask

   task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int wc,
                            input logic [7:0] seed, input logic [31:0] hflip,
                            input bit crc_bad, input bit expect_out, input int max_words,
                            input string tag);
      logic [7:0]  b [0:63];
      logic [15:0] crc;
      logic [31:0] w32;
      logic [31:0] exp_d;
      logic [3:0]  kp;
      int          nw;
      int          full_nw;
      crc = 16'hFFFF;
      for (int i = 0; i < 64; i++) b[i] = 8'h00;
      for (int i = 0; i < wc; i++) begin
         b[i] = seed + 8'(i * 37);
         crc  = crc_upd(crc, b[i]);
      end
      if (crc_bad) crc ^= 16'h0100;
      b[wc]     = crc[7:0];
      b[wc + 1] = crc[15:8];
      for (int i = wc + 2; i < 64; i++) b[i] = 8'hA5;
      full_nw = (wc + 5) / 4;
      nw = (max_words >= 0 && max_words < full_nw) ? max_words : full_nw;
      send_word(1'b1, make_hdr(vc, dt, 16'(wc)) ^ hflip);
      for (int w = 0; w < nw; w++) begin
         w32 = {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
         if (expect_out && 4 * w < wc) begin
            for (int k = 0; k < 4; k++) begin
               kp[k]          = (4 * w + k) < wc;
               exp_d[8*k +: 8] = kp[k] ? b[4*w+k] : 8'h00;
            end
            pay_q.push_back('{exp_d, kp, (w == 0), (4 * w + 4 >= wc), vc, dt, tag});
         end
         send_word(1'b0, w32);
      end
      if (expect_out) end_q.push_back('{(nw == full_nw) ? crc_bad : 1'b0, (nw < full_nw), tag});
   endtask

   task automatic check_status(input logic [4:0] exp_st, input logic exp_irq, input string tag);
      idle(3);
      check_eq(tag, "status", 32'(status), 32'(exp_st));
      check_eq(tag, "irq", 32'(irq), 32'(exp_irq));
   endtask

   task automatic clear_all();
      @(negedge clk);
      status_clr = 5'h1F;
      @(negedge clk);
      status_clr = '0;
   endtask

   // monitor: pops expected items as the outputs appear
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (sp_valid) begin
            if (sp_q.size() == 0) check_eq("R1", "unexpected short packet", 32'(sp_data), 32'hX);
            else begin
               sp_item_t e;
               e = sp_q.pop_front();
               check_eq(e.tag, "short vc/dt/data", {8'h00, sp_vc, sp_dt, sp_data},
                        {8'h00, e.vc, e.dt, e.data});
            end
         end
         if (pay_valid) begin
            if (pay_q.size() == 0) check_eq("R2", "unexpected payload", pay_data, 32'hX);
            else begin
               pay_item_t e;
               e = pay_q.pop_front();
               check_eq(e.tag, "payload data", pay_data, e.data);
               check_eq(e.tag, "payload keep/first/last/vc/dt",
                        {16'h0, pay_keep, pay_first, pay_last, pay_vc, pay_dt},
                        {16'h0, e.keep, e.first, e.last, e.vc, e.dt});
            end
         end
         if (end_valid) begin
            if (end_q.size() == 0) check_eq("R5", "unexpected end", 32'(end_crc_err), 32'hX);
            else begin
               end_item_t e;
               e = end_q.pop_front();
               check_eq(e.tag, "end crc_err/trunc", {30'h0, end_crc_err, end_trunc},
                        {30'h0, e.crc_err, e.trunc});
            end
         end
      end
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12 reset state
      check_eq("R12", "pulses in reset", {29'h0, sp_valid, pay_valid, end_valid}, 32'h0);
      check_eq("R12", "status in reset", 32'(status), 32'h0);
      check_eq("R12", "irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R1 short packet, R2 and R5 clean long packets
      send_short(2'd0, 6'h01, 16'h1234, 32'h0, 1'b1, "R1");
      send_long(2'd1, 6'h2A, 5, 8'h10, 32'h0, 1'b0, 1'b1, -1, "R2");
      send_long(2'd2, 6'h1E, 0, 8'h00, 32'h0, 1'b0, 1'b1, -1, "R2_wc0");
      // R7 interleaving, short/long boundary types back to back
      send_short(2'd3, 6'h0F, 16'hBEEF, 32'h0, 1'b1, "R7");
      send_long(2'd0, 6'h10, 7, 8'h33, 32'h0, 1'b0, 1'b1, -1, "R7");
      send_short(2'd2, 6'h02, 16'h0042, 32'h0, 1'b1, "R7");
      send_long(2'd3, 6'h2B, 40, 8'h7C, 32'h0, 1'b0, 1'b1, -1, "R2_long");
      check_status(5'b00000, 1'b0, "R5");

      // R3 single-bit repairs: word count bit, then a code bit
      send_long(2'd1, 6'h24, 6, 8'h5A, 32'h0000_1000, 1'b0, 1'b1, -1, "R3");
      send_short(2'd2, 6'h03, 16'hA0A0, 32'h0800_0000, 1'b1, "R3");
      check_status(5'b00010, 1'b0, "R3");
      clear_all();
      check_status(5'b00000, 1'b0, "R10");

      // R4 double-bit error: whole packet dropped, resume at next start flag
      send_long(2'd1, 6'h2A, 8, 8'h11, 32'h0000_0201, 1'b0, 1'b0, -1, "R4");
      send_short(2'd0, 6'h04, 16'h5555, 32'h0, 1'b1, "R4");
      check_status(5'b00100, 1'b1, "R4");
      clear_all();

      // R5 checksum mismatch
      send_long(2'd2, 6'h2C, 9, 8'h90, 32'h0, 1'b1, 1'b1, -1, "R5");
      check_status(5'b01000, 1'b1, "R5");
      clear_all();

      // R6 channel filter
      @(negedge clk);
      vc_enable = 4'b1011;
      send_long(2'd2, 6'h2A, 6, 8'h21, 32'h0, 1'b1, 1'b0, -1, "R6");
      send_short(2'd2, 6'h05, 16'h7777, 32'h0, 1'b0, "R6");
      send_short(2'd1, 6'h05, 16'h8888, 32'h0, 1'b1, "R6");
      check_status(5'b00000, 1'b0, "R6");
      vc_enable = 4'hF;

      // R8 truncation by a new start flag
      send_long(2'd1, 6'h2A, 12, 8'h44, 32'h0, 1'b0, 1'b1, 2, "R8");
      send_short(2'd3, 6'h06, 16'h1111, 32'h0, 1'b1, "R8");
      check_status(5'b10000, 1'b1, "R8");
      clear_all();

      // R9 stray word while idle
      send_word(1'b0, 32'hDEAD_BEEF);
      check_status(5'b10000, 1'b1, "R9");
      clear_all();

      // R11 physical-layer error, R10 interrupt masking per class
      @(negedge clk);
      in_phy_err = 1'b1;
      @(negedge clk);
      in_phy_err = 1'b0;
      check_status(5'b00001, 1'b1, "R11");
      irq_enable = 3'b110;
      check_status(5'b00001, 1'b0, "R10");
      irq_enable = 3'b111;
      clear_all();
      check_status(5'b00000, 1'b0, "R10");

      idle(5);
      check_eq("R1", "short items left", 32'(sp_q.size()), 32'h0);
      check_eq("R2", "payload items left", 32'(pay_q.size()), 32'h0);
      check_eq("R5", "end items left", 32'(end_q.size()), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule